// File: doc/BRIEF.md
# Single-Wire Bus Slot Responder

This block is the device-side physical layer of an open-drain single-wire bus. It uses a one-microsecond tick. It watches the sampled line level. When the master holds the line low long enough, the block treats this as a bus reset. After the master releases the line, the block waits a fixed delay and then pulls the line low for a fixed time to announce that it is present. Every shorter low pulse that starts on a falling edge is taken as a time slot. The block times each slot from that falling edge, not from a shared clock.

In a write slot the block samples the line at a fixed point after the falling edge. It reports the bit on a one-cycle valid strobe once the slot is known to be well-formed. In a read slot the block sends the bit supplied on its transmit input. It sends a zero by holding the line low past the master's sampling point and leaves the line alone for a one. The slot type and the bit to send are captured at the falling edge. A low pulse too long for a slot but too short for a reset produces nothing. Decoding of commands is left to the logic above.

Top module: `swb_responder`

## Requirements
- R1: While `rst` is high and in the cycle after it, `drive_low`, `rx_valid` and `reset_seen` are all low.
- R2: A reset is recognized when the line is still low at the edge of the 480th tick after the falling edge was seen. When the line is first seen high again after that, `reset_seen` is high for exactly one cycle, the cycle after that rise. If the line is already high at the edge of the 480th tick, the pulse is not a reset.
- R3: After a recognized reset, `drive_low` rises in the cycle after the 30th tick that follows the rise. It then stays high for exactly 120 ticks.
- R4: In a write slot (`read_mode` = 0 at the falling edge), the line is sampled at the 30th tick after the falling edge. High gives bit 1 and low gives bit 0. The bit appears on `rx_bit` together with a single-cycle `rx_valid` once the sample is taken and the line is high.
- R5: In a read slot (`read_mode` = 1 at the falling edge) with `tx_bit` = 0, `drive_low` is high from the cycle after the falling edge is seen until the 45th tick after it, so the line reads low 14 µs into the slot.
- R6: In a read slot with `tx_bit` = 1, `drive_low` stays low for the whole slot, so the line reads high 14 µs into the slot.
- R7: A low pulse that is still low at the 120th tick after its falling edge, but is released before it becomes a reset, produces no `rx_valid`, no `reset_seen` and no presence drive.
- R8: Falling edges seen during the presence delay or the presence drive start no slot. This includes the fall made by the block's own presence pulse, so no `rx_valid` comes out of them.
- R9: `read_mode` and `tx_bit` are captured at the falling edge. Changing them later in the same slot does not change that slot's behaviour.
- R10: A read slot never produces `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| line_in | input | 1 | Synchronized level of the bus line (1 = high) |
| tx_bit | input | 1 | Bit to send in a read slot, captured at the falling edge |
| read_mode | input | 1 | 1 = next slot is a read slot, 0 = write slot, captured at the falling edge |
| drive_low | output | 1 | Enable for the open-drain pull-down of the line |
| rx_bit | output | 1 | Last bit received in a write slot |
| rx_valid | output | 1 | One-cycle strobe, `rx_bit` is new |
| reset_seen | output | 1 | One-cycle pulse when a bus reset has ended |

## Verification
Two timing decisions can land in the same clock cycle. One is the master releasing the line, and the other is the tick that takes the low-time count to the reset threshold. The bench lines up its falling edges with the tick. It releases the line exactly on the 480th tick in one case and one tick later in another. In the first case it expects nothing to happen, and in the second a reset with presence. A behavioural reference model, compared on every clock, judges both cases cycle by cycle, along with the direct counts of strobes and of cycles the line is driven.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SLOT   = 3'd1,
    ST_LONG   = 3'd2,
    ST_RSTLOW = 3'd3,
    ST_PDELAY = 3'd4,
    ST_PRES   = 3'd5
  } swb_state_e;

  typedef struct packed {
    logic rd;
    logic tx;
  } slot_cfg_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swb_edge_det.sv
module swb_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic fall
);
  logic line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b1;
    else     line_q <= line_in;
  end

  assign fall = line_q & ~line_in;
endmodule

// File: rtl/swb_us_timer.sv
module swb_us_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/swb_slot_fsm.sv
module swb_slot_fsm
  import swb_pkg::*;
#(
  parameter int W             = 9,
  parameter int RESET_MIN_US  = 480,
  parameter int SLOT_MAX_US   = 120,
  parameter int SAMPLE_US     = 30,
  parameter int HOLD_US       = 45,
  parameter int PRES_DELAY_US = 30,
  parameter int PRES_WIDTH_US = 120
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_us,
  input  logic         line_in,
  input  logic         fall,
  input  logic         tx_bit,
  input  logic         read_mode,
  input  logic [W-1:0] cnt,
  output logic         cnt_clr,
  output logic         cnt_inc,
  output logic         drive_low,
  output logic         rx_bit,
  output logic         rx_valid,
  output logic         reset_seen
);
  localparam logic [W-1:0] C_RESET  = W'(RESET_MIN_US);
  localparam logic [W-1:0] C_SLOT   = W'(SLOT_MAX_US);
  localparam logic [W-1:0] C_SAMPLE = W'(SAMPLE_US);
  localparam logic [W-1:0] C_HOLD   = W'(HOLD_US);
  localparam logic [W-1:0] C_PDLY   = W'(PRES_DELAY_US);
  localparam logic [W-1:0] C_PWID   = W'(PRES_WIDTH_US);

  swb_state_e state, state_n;
  slot_cfg_t  cfg, cfg_n;
  logic       have, have_n;
  logic       samp, samp_n;
  logic       drive_n, rxv_n, rxb_n, rst_n;
  logic [W-1:0] cnt_nx, cnt_after;

  assign cnt_nx = cnt + 1'b1;

  always_comb begin
    state_n = state;
    cfg_n   = cfg;
    have_n  = have;
    samp_n  = samp;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    rxv_n   = 1'b0;
    rxb_n   = rx_bit;
    rst_n   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (fall) begin
          state_n  = ST_SLOT;
          cnt_clr  = 1'b1;
          cfg_n.rd = read_mode;
          cfg_n.tx = tx_bit;
          have_n   = 1'b0;
        end
      end
      ST_SLOT: begin
        if (!cfg.rd && have && line_in) begin
          rxv_n   = 1'b1;
          rxb_n   = samp;
          have_n  = 1'b0;
          state_n = ST_IDLE;
        end else if (cfg.rd && cnt >= C_HOLD && line_in) begin
          state_n = ST_IDLE;
        end else if (tick_us) begin
          cnt_inc = 1'b1;
          if (!cfg.rd && cnt_nx == C_SAMPLE) begin
            samp_n = line_in;
            have_n = 1'b1;
          end
          if (cnt_nx == C_SLOT && !line_in) begin
            state_n = ST_LONG;
            have_n  = 1'b0;
          end
        end
      end
      ST_LONG: begin
        if (line_in) begin
          state_n = ST_IDLE;
        end else if (tick_us) begin
          cnt_inc = 1'b1;
          if (cnt_nx == C_RESET) state_n = ST_RSTLOW;
        end
      end
      ST_RSTLOW: begin
        if (line_in) begin
          state_n = ST_PDELAY;
          cnt_clr = 1'b1;
          rst_n   = 1'b1;
        end
      end
      ST_PDELAY: begin
        if (tick_us) begin
          cnt_inc = 1'b1;
          if (cnt_nx == C_PDLY) begin
            state_n = ST_PRES;
            cnt_clr = 1'b1;
          end
        end
      end
      ST_PRES: begin
        if (tick_us) begin
          cnt_inc = 1'b1;
          if (cnt_nx == C_PWID) state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    if (cnt_clr)      cnt_after = '0;
    else if (cnt_inc) cnt_after = cnt_nx;
    else              cnt_after = cnt;
    drive_n = (state_n == ST_PRES) ||
              (state_n == ST_SLOT && cfg_n.rd && !cfg_n.tx && cnt_after < C_HOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cfg        <= '0;
      have       <= 1'b0;
      samp       <= 1'b0;
      drive_low  <= 1'b0;
      rx_bit     <= 1'b0;
      rx_valid   <= 1'b0;
      reset_seen <= 1'b0;
    end else begin
      state      <= state_n;
      cfg        <= cfg_n;
      have       <= have_n;
      samp       <= samp_n;
      drive_low  <= drive_n;
      rx_bit     <= rxb_n;
      rx_valid   <= rxv_n;
      reset_seen <= rst_n;
    end
  end
endmodule

// File: rtl/swb_responder.sv
module swb_responder
  import swb_pkg::*;
#(
  parameter int RESET_MIN_US  = 480,
  parameter int SLOT_MAX_US   = 120,
  parameter int SAMPLE_US     = 30,
  parameter int HOLD_US       = 45,
  parameter int PRES_DELAY_US = 30,
  parameter int PRES_WIDTH_US = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic line_in,
  input  logic tx_bit,
  input  logic read_mode,
  output logic drive_low,
  output logic rx_bit,
  output logic rx_valid,
  output logic reset_seen
);
  localparam int unsigned LIMIT = max2(max2(RESET_MIN_US, SLOT_MAX_US),
                                       max2(PRES_DELAY_US, PRES_WIDTH_US));
  localparam int CW = $clog2(LIMIT + 2);

  logic          fall, cnt_clr, cnt_inc;
  logic [CW-1:0] cnt;

  swb_edge_det u_edge (
    .clk(clk), .rst(rst), .line_in(line_in), .fall(fall)
  );

  swb_us_timer #(.W(CW)) u_timer (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  swb_slot_fsm #(
    .W(CW), .RESET_MIN_US(RESET_MIN_US), .SLOT_MAX_US(SLOT_MAX_US),
    .SAMPLE_US(SAMPLE_US), .HOLD_US(HOLD_US),
    .PRES_DELAY_US(PRES_DELAY_US), .PRES_WIDTH_US(PRES_WIDTH_US)
  ) u_fsm (
    .clk(clk), .rst(rst), .tick_us(tick_us), .line_in(line_in), .fall(fall),
    .tx_bit(tx_bit), .read_mode(read_mode), .cnt(cnt),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .drive_low(drive_low),
    .rx_bit(rx_bit), .rx_valid(rx_valid), .reset_seen(reset_seen)
  );
endmodule

// File: rtl/swb_responder_chk.sv
module swb_responder_chk (
  input logic clk,
  input logic rst,
  input logic line_in,
  input logic drive_low,
  input logic rx_valid,
  input logic reset_seen
);
  // R1
  quiet_after_rst_chk: assert property (@(posedge clk)
    rst |=> (!drive_low && !rx_valid && !reset_seen));

  // R2
  reset_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    reset_seen |=> !reset_seen);

  // R2
  reset_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    reset_seen |-> $past(line_in));

  // R3
  no_instant_presence_chk: assert property (@(posedge clk) disable iff (rst)
    reset_seen |-> !drive_low);

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R10
  strobe_not_driving_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !drive_low);
endmodule

bind swb_responder swb_responder_chk u_chk (
  .clk(clk), .rst(rst), .line_in(line_in), .drive_low(drive_low),
  .rx_valid(rx_valid), .reset_seen(reset_seen)
);

// File: tb/swb_responder_bench.sv
module swb_responder_bench;
  localparam int TDIV     = 4;
  localparam int RST_MIN  = 480;
  localparam int SLOT_MAX = 120;
  localparam int SAMPLE   = 30;
  localparam int HOLD     = 45;
  localparam int PDLY     = 30;
  localparam int PWID     = 120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b0;
  logic tx_bit = 1'b0;
  logic read_mode = 1'b0;
  logic master_low = 1'b0;
  logic line_in;
  logic drive_low, rx_bit, rx_valid, reset_seen;

  assign line_in = ~(master_low | drive_low);

  always #2.5 clk = ~clk;

  swb_responder u_swb_responder (
    .clk(clk), .rst(rst), .tick_us(tick_us), .line_in(line_in),
    .tx_bit(tx_bit), .read_mode(read_mode), .drive_low(drive_low),
    .rx_bit(rx_bit), .rx_valid(rx_valid), .reset_seen(reset_seen)
  );

  int divcnt = 0;
  always @(negedge clk) begin
    divcnt  <= (divcnt == TDIV-1) ? 0 : divcnt + 1;
    tick_us <= (divcnt == TDIV-1);
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: 0 idle 1 slot 2 long 3 reset-low 4 delay 5 presence
  int m_st = 0, m_cnt = 0;
  bit m_rd, m_tx, m_have, m_samp, m_lq;
  bit e_drive, e_rxv, e_rxb, e_rst;
  always @(posedge clk) begin
    bit ln, fl;
    ln = line_in;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_lq = 1; m_have = 0; m_samp = 0; m_rd = 0; m_tx = 0;
      e_drive = 0; e_rxv = 0; e_rxb = 0; e_rst = 0;
    end else begin
      fl = m_lq && !ln;
      m_lq = ln;
      e_rxv = 0;
      e_rst = 0;
      case (m_st)
        0: if (fl) begin m_st = 1; m_cnt = 0; m_rd = read_mode; m_tx = tx_bit; m_have = 0; end
        1: begin
          if (!m_rd && m_have && ln) begin
            e_rxv = 1; e_rxb = m_samp; m_have = 0; m_st = 0;
          end else if (m_rd && m_cnt >= HOLD && ln) begin
            m_st = 0;
          end else if (tick_us) begin
            m_cnt++;
            if (!m_rd && m_cnt == SAMPLE) begin m_samp = ln; m_have = 1; end
            if (m_cnt == SLOT_MAX && !ln) begin m_st = 2; m_have = 0; end
          end
        end
        2: if (ln) m_st = 0;
           else if (tick_us) begin m_cnt++; if (m_cnt == RST_MIN) m_st = 3; end
        3: if (ln) begin m_st = 4; m_cnt = 0; e_rst = 1; end
        4: if (tick_us) begin m_cnt++; if (m_cnt == PDLY) begin m_st = 5; m_cnt = 0; end end
        5: if (tick_us) begin m_cnt++; if (m_cnt == PWID) m_st = 0; end
        default: m_st = 0;
      endcase
      e_drive = (m_st == 5) || (m_st == 1 && m_rd && !m_tx && m_cnt < HOLD);
    end
  end

  bit cmp_on = 0;
  bit rx_q[$];
  int rs_cnt = 0, run = 0, last_run = 0, runs = 0, cyc = 0;
  bit done = 0;

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      chk(drive_low === e_drive, "R3/R5/R6 drive_low vs model", int'(drive_low), int'(e_drive));
      chk(rx_valid === e_rxv, "R4/R7/R10 rx_valid vs model", int'(rx_valid), int'(e_rxv));
      if (e_rxv) chk(rx_bit === e_rxb, "R4 rx_bit vs model", int'(rx_bit), int'(e_rxb));
      chk(reset_seen === e_rst, "R2 reset_seen vs model", int'(reset_seen), int'(e_rst));
      if (rx_valid) rx_q.push_back(rx_bit);
      if (reset_seen) rs_cnt++;
      if (drive_low) run++;
      else if (run > 0) begin last_run = run; run = 0; runs++; end
    end
    if (cyc > 150000 && !done) begin
      chk(0, "watchdog expired", cyc, 150000);
      finish_run();
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic align();
    do @(negedge clk); while (divcnt != TDIV-1);
  endtask

  task automatic write_slot(input bit b, input bit flip);
    int n0 = rx_q.size();
    align();
    read_mode = 0;
    master_low = 1;
    if (b) begin
      wait_cycles(2*TDIV); master_low = 0;
      wait_cycles(8*TDIV); if (flip) read_mode = 1;
      wait_cycles(60*TDIV);
    end else begin
      wait_cycles(10*TDIV); if (flip) read_mode = 1;
      wait_cycles(55*TDIV); master_low = 0;
      wait_cycles(5*TDIV);
    end
    chk(rx_q.size() == n0 + 1, flip ? "R9 write bit count" : "R4 write bit count", rx_q.size(), n0 + 1);
    if (rx_q.size() > 0) chk(rx_q[$] == b, flip ? "R9 write bit value" : "R4 write bit value", int'(rx_q[$]), int'(b));
    read_mode = 0;
  endtask

  task automatic read_slot(input bit txb, input bit flip, output bit sensed);
    int n0 = rx_q.size();
    int r0 = runs;
    align();
    read_mode = 1;
    tx_bit = txb;
    master_low = 1;
    wait_cycles(TDIV);
    master_low = 0;
    wait_cycles(4*TDIV);
    if (flip) begin read_mode = 0; tx_bit = ~txb; end
    wait_cycles(9*TDIV);
    sensed = line_in;
    wait_cycles(56*TDIV);
    chk(rx_q.size() == n0, "R10 no strobe in read slot", rx_q.size(), n0);
    if (!txb) begin
      chk(runs == r0 + 1, flip ? "R9 read zero drive count" : "R5 read zero drive count", runs, r0 + 1);
      chk(last_run == HOLD*TDIV, flip ? "R9 read zero hold" : "R5 read zero hold", last_run, HOLD*TDIV);
    end else begin
      chk(runs == r0, "R6 read one never driven", runs, r0);
    end
    read_mode = 0;
    tx_bit = 0;
  endtask

  task automatic bus_reset(input int low_cycles, input bit expect_rst, input bit glitch);
    int r0 = rs_cnt, q0 = rx_q.size(), d0 = runs, dly = 0;
    align();
    master_low = 1;
    wait_cycles(low_cycles);
    master_low = 0;
    if (expect_rst) begin
      if (glitch) begin
        wait_cycles(10*TDIV); master_low = 1; wait_cycles(5*TDIV); master_low = 0;
        wait_cycles(200*TDIV);
      end else begin
        for (int i = 0; i < 400; i++) begin
          @(negedge clk);
          dly++;
          if (drive_low) break;
        end
        chk(dly == PDLY*TDIV + 1, "R3 presence delay", dly, PDLY*TDIV + 1);
        wait_cycles(200*TDIV);
      end
      chk(rs_cnt == r0 + 1, "R2 reset recognized", rs_cnt, r0 + 1);
      chk(last_run == PWID*TDIV, "R3 presence width", last_run, PWID*TDIV);
      chk(runs == d0 + 1, glitch ? "R8 single presence" : "R3 single presence", runs, d0 + 1);
      chk(rx_q.size() == q0, glitch ? "R8 no slot from presence" : "R8 no strobe", rx_q.size(), q0);
    end else begin
      wait_cycles(200*TDIV);
      chk(rs_cnt == r0, "R7 no reset", rs_cnt, r0);
      chk(runs == d0, "R7 no presence", runs, d0);
      chk(rx_q.size() == q0, "R7 no bit", rx_q.size(), q0);
    end
  endtask

  initial begin
    bit s;
    wait_cycles(5);
    chk(!drive_low && !rx_valid && !reset_seen, "R1 outputs during reset",
        int'({drive_low, rx_valid, reset_seen}), 0);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    chk(!drive_low && !rx_valid && !reset_seen, "R1 outputs after reset",
        int'({drive_low, rx_valid, reset_seen}), 0);

    bus_reset(500*TDIV, 1, 0);
    write_slot(1, 0);
    write_slot(0, 0);
    write_slot(1, 0);
    write_slot(1, 0);
    write_slot(0, 0);
    read_slot(0, 0, s);
    chk(s == 0, "R5 line low at master sample", int'(s), 0);
    read_slot(1, 0, s);
    chk(s == 1, "R6 line high at master sample", int'(s), 1);
    read_slot(0, 1, s);
    chk(s == 0, "R9 line low despite late change", int'(s), 0);
    write_slot(0, 1);
    write_slot(1, 1);
    bus_reset(200*TDIV, 0, 0);
    bus_reset(RST_MIN*TDIV, 0, 0);
    bus_reset(RST_MIN*TDIV + TDIV, 1, 0);
    bus_reset(500*TDIV, 1, 1);
    write_slot(0, 0);
    write_slot(1, 0);

    done = 1;
    finish_run();
  end
endmodule